// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block answers the processor's interrupt acknowledge strobes with vectoring bytes. It follows one of two bus styles. In the byte-wide style, each acknowledge sequence has three pulses. The first pulse returns a subroutine call opcode, and the next two return the handler address, low byte first. The handler address is a programmed base plus the level scaled by a spacing of 4 or 8 bytes. In the word-wide style, each sequence has two pulses. The first pulse leaves the bus undriven, and the second returns an 8-bit pointer. The pointer's upper five bits are programmed and its lower three bits are the level.

The strobe is asynchronous to the clock, so the block synchronizes it and counts pulses on its falling edges. At the first pulse it latches the winning level from the arbiter and gives the arbiter a one-cycle in-service set pulse. If no valid request is present at that moment, the level is forced to 7 for the whole sequence. When the last pulse of the sequence ends and automatic end-of-interrupt is enabled, it gives a one-cycle clear pulse. The counter then returns to idle, ready for the next sequence.

Top module: `inta_vector_seq`

## Requirements
- R1: After reset, drive_o is 0, data_o is 0, and neither isr_set_o nor aeoi_clr_o pulses until an acknowledge pulse arrives.
- R2: With mode16_i=0, data_o is 8'hCD while the first pulse of a sequence is low.
- R3: With mode16_i=0, the second pulse returns bits [7:0] and the third pulse returns bits [15:8] of base_addr_i + level*S. S is 4 when spacing8_i=0 and 8 when spacing8_i=1.
- R4: With mode16_i=1, drive_o stays 0 and data_o stays 0 throughout the first pulse.
- R5: In both modes, isr_set_o pulses for exactly one clock per sequence, right after the first pulse falls. level_o then holds the level latched at that pulse. Later changes to req_level_i do not alter that level.
- R6: With mode16_i=1, the second pulse returns {vec_base_i, level}.
- R7: When the final pulse of the selected mode ends, aeoi_clr_o pulses for exactly one clock if aeoi_en_i=1, and does not pulse if aeoi_en_i=0.
- R8: If req_valid_i=0 at the first pulse, level_o is 7 and every byte of that sequence is the byte for level 7.
- R9: drive_o is 1 only while the synchronized strobe is low during a pulse that returns data. data_o is 0 whenever drive_o is 0.
- R10: After the final pulse, the sequencer is idle again. The next pulse starts a new sequence in the mode selected at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inta_ni | input | 1 | Active-low acknowledge strobe, asynchronous |
| mode16_i | input | 1 | 1 selects the two-pulse pointer style, 0 selects the three-byte call style |
| req_valid_i | input | 1 | The arbiter has a winning request |
| req_level_i | input | 3 | Winning level |
| base_addr_i | input | 16 | Handler table base for the call style |
| vec_base_i | input | 5 | Upper pointer bits for the pointer style |
| spacing8_i | input | 1 | Handler spacing: 1 selects 8 bytes, 0 selects 4 bytes |
| aeoi_en_i | input | 1 | Automatic end-of-interrupt enable |
| data_o | output | 8 | Vector byte |
| drive_o | output | 1 | Data bus drive enable |
| isr_set_o | output | 1 | One-cycle in-service set pulse |
| aeoi_clr_o | output | 1 | One-cycle automatic in-service clear pulse |
| level_o | output | 3 | Level latched for the current sequence |

## Verification
The bench covers several corner cases, each paired with the mistake it would expose:
- **Request withdrawn before the first pulse.** A design that skipped the level-7 substitution would return the stale level's address or pointer.
- **Level change in mid-sequence.** A design that read req_level_i live would mix two levels in one address.
- **Silent first pulse of the pointer style.** A design that drove the bus there would collide with other bus drivers.
- **Both spacings, with the level at 7 and with a base near the top of the range.** These catch a wrong shift, and also a carry that does not reach the high byte.
- **Automatic clear, on and off, in both modes.** A counter that used the wrong final pulse would clear too early, or would never return to idle and would wrongly sequence the next acknowledge.

// File: rtl/inta_seq_pkg.sv
package inta_seq_pkg;
  typedef enum logic [1:0] {
    P_IDLE  = 2'd0,
    P_ONE   = 2'd1,
    P_TWO   = 2'd2,
    P_THREE = 2'd3
  } pulse_e;

  localparam logic [7:0] CALL_OPCODE = 8'hCD;
endpackage

// File: rtl/inta_strobe_sync.sv
module inta_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inta_ni,
  output logic low_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b1;
        else if (i == 0) chain_q[i] <= inta_ni;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign low_o  = ~chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
  assign rise_o = ~prev_q & chain_q[STAGES-1];
endmodule

// File: rtl/inta_pulse_seq.sv
module inta_pulse_seq
  import inta_seq_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic             mode16_i,
  input  logic             req_valid_i,
  input  logic [LVL_W-1:0] req_level_i,
  input  logic             aeoi_en_i,
  output pulse_e           idx_o,
  output logic             mode16_o,
  output logic [LVL_W-1:0] level_o,
  output logic             isr_set_o,
  output logic             aeoi_clr_o
);
  localparam logic [LVL_W-1:0] FALLBACK_LVL = {LVL_W{1'b1}};

  pulse_e idx_q;
  logic   last_pulse;

  assign last_pulse = mode16_o ? (idx_q == P_TWO) : (idx_q == P_THREE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= P_IDLE;
      mode16_o   <= 1'b0;
      level_o    <= '0;
      isr_set_o  <= 1'b0;
      aeoi_clr_o <= 1'b0;
    end else begin
      isr_set_o  <= 1'b0;
      aeoi_clr_o <= 1'b0;
      if (fall_i) begin
        unique case (idx_q)
          P_IDLE: begin
            idx_q     <= P_ONE;
            mode16_o  <= mode16_i;
            level_o   <= req_valid_i ? req_level_i : FALLBACK_LVL;
            isr_set_o <= 1'b1;
          end
          P_ONE:   idx_q <= P_TWO;
          P_TWO:   idx_q <= P_THREE;
          P_THREE: idx_q <= P_THREE;
          default: idx_q <= P_IDLE;
        endcase
      end else if (rise_i && last_pulse) begin
        idx_q      <= P_IDLE;
        aeoi_clr_o <= aeoi_en_i;
      end
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/inta_byte_fmt.sv
module inta_byte_fmt
  import inta_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int VB_W   = DATA_W - LVL_W
) (
  input  pulse_e            idx_i,
  input  logic              mode16_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [VB_W-1:0]   vec_base_i,
  input  logic              spacing8_i,
  input  logic              strobe_low_i,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] handler;
  logic [DATA_W-1:0] byte_sel;
  logic              data_pulse;

  assign offset  = ADDR_W'(level_i) << (spacing8_i ? 3 : 2);
  assign handler = base_addr_i + offset;

  always_comb begin
    byte_sel   = '0;
    data_pulse = 1'b0;
    if (mode16_i) begin
      if (idx_i == P_TWO) begin
        byte_sel   = {vec_base_i, level_i};
        data_pulse = 1'b1;
      end
    end else begin
      unique case (idx_i)
        P_ONE:   begin byte_sel = CALL_OPCODE;             data_pulse = 1'b1; end
        P_TWO:   begin byte_sel = handler[DATA_W-1:0];      data_pulse = 1'b1; end
        P_THREE: begin byte_sel = handler[ADDR_W-1:DATA_W]; data_pulse = 1'b1; end
        default: ;
      endcase
    end
  end

  assign drive_o = data_pulse & strobe_low_i;
  assign data_o  = drive_o ? byte_sel : '0;
endmodule

// File: rtl/inta_vector_seq.sv
module inta_vector_seq
  import inta_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LVL_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int VB_W   = DATA_W - LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inta_ni,
  input  logic              mode16_i,
  input  logic              req_valid_i,
  input  logic [LVL_W-1:0]  req_level_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [VB_W-1:0]   vec_base_i,
  input  logic              spacing8_i,
  input  logic              aeoi_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o,
  output logic              isr_set_o,
  output logic              aeoi_clr_o,
  output logic [LVL_W-1:0]  level_o
);
  logic   strobe_low, strobe_fall, strobe_rise;
  pulse_e idx;
  logic   mode16_q;

  inta_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inta_ni(inta_ni),
    .low_o  (strobe_low),
    .fall_o (strobe_fall),
    .rise_o (strobe_rise)
  );

  inta_pulse_seq #(.LVL_W(LVL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (strobe_fall),
    .rise_i     (strobe_rise),
    .mode16_i   (mode16_i),
    .req_valid_i(req_valid_i),
    .req_level_i(req_level_i),
    .aeoi_en_i  (aeoi_en_i),
    .idx_o      (idx),
    .mode16_o   (mode16_q),
    .level_o    (level_o),
    .isr_set_o  (isr_set_o),
    .aeoi_clr_o (aeoi_clr_o)
  );

  inta_byte_fmt #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_fmt (
    .idx_i       (idx),
    .mode16_i    (mode16_q),
    .level_i     (level_o),
    .base_addr_i (base_addr_i),
    .vec_base_i  (vec_base_i),
    .spacing8_i  (spacing8_i),
    .strobe_low_i(strobe_low),
    .data_o      (data_o),
    .drive_o     (drive_o)
  );
endmodule

// File: rtl/inta_vector_seq_chk.sv
module inta_vector_seq_chk
  import inta_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              drive_o,
  input logic              isr_set_o,
  input logic              aeoi_clr_o,
  input logic              aeoi_en_i,
  input logic              strobe_low_i,
  input pulse_e            idx_i,
  input logic              mode16_i
);
  AST_ISR_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_set_o |=> !isr_set_o); // R5

  AST_ISR_ON_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_set_o |-> idx_i == P_ONE); // R5

  AST_CLR_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aeoi_clr_o |-> $past(aeoi_en_i)); // R7

  AST_CLR_RETURNS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aeoi_clr_o |-> idx_i == P_IDLE); // R10

  AST_DRIVE_WHILE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> strobe_low_i); // R9

  AST_QUIET_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> data_o == '0); // R9

  AST_SILENT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && mode16_i) |-> idx_i == P_TWO); // R4

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode16_i |-> idx_i != P_THREE); // R10
endmodule

bind inta_vector_seq inta_vector_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_o      (data_o),
  .drive_o     (drive_o),
  .isr_set_o   (isr_set_o),
  .aeoi_clr_o  (aeoi_clr_o),
  .aeoi_en_i   (aeoi_en_i),
  .strobe_low_i(strobe_low),
  .idx_i       (idx),
  .mode16_i    (mode16_q)
);

// File: tb/inta_vector_seq_test.sv
`timescale 1ns/1ps
module inta_vector_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inta_n = 1'b1;
  logic        mode16 = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_level = '0;
  logic [15:0] base_addr = '0;
  logic [4:0]  vec_base = '0;
  logic        spacing8 = 1'b0;
  logic        aeoi_en = 1'b0;
  logic [7:0]  data;
  logic        drive, isr_set, aeoi_clr;
  logic [2:0]  level;

  int checks = 0;
  int failures = 0;
  int isr_cnt = 0;
  int clr_cnt = 0;
  logic [2:0] isr_lvl = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  inta_vector_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .inta_ni(inta_n), .mode16_i(mode16),
    .req_valid_i(req_valid), .req_level_i(req_level), .base_addr_i(base_addr),
    .vec_base_i(vec_base), .spacing8_i(spacing8), .aeoi_en_i(aeoi_en),
    .data_o(data), .drive_o(drive), .isr_set_o(isr_set), .aeoi_clr_o(aeoi_clr),
    .level_o(level)
  );

  always @(posedge clk) begin
    if (isr_set) begin isr_cnt <= isr_cnt + 1; isr_lvl <= level; end
    if (aeoi_clr) clr_cnt <= clr_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {drive, data} expected while pulse p is low
  function automatic logic [8:0] exp_byte(input logic m16, input int p, input logic [2:0] lv,
                                          input logic [15:0] base, input logic [4:0] vb,
                                          input logic sp8);
    logic [15:0] a;
    a = base + (16'(lv) * (sp8 ? 16'd8 : 16'd4));
    if (m16) return (p == 2) ? {1'b1, vb, lv} : 9'h000;
    case (p)
      1: return {1'b1, 8'hCD};
      2: return {1'b1, a[7:0]};
      default: return {1'b1, a[15:8]};
    endcase
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_seq(input logic m16, input logic vld, input logic [2:0] lv,
                         input logic [15:0] base, input logic [4:0] vb,
                         input logic sp8, input logic ae, input logic [2:0] lv_late);
    int npulse;
    logic [2:0] elv;
    logic [8:0] e;
    int isr0, clr0;
    npulse = m16 ? 2 : 3;
    elv = vld ? lv : 3'd7;
    @(negedge clk);
    mode16 = m16; req_valid = vld; req_level = lv; base_addr = base;
    vec_base = vb; spacing8 = sp8; aeoi_en = ae;
    isr0 = isr_cnt; clr0 = clr_cnt;
    for (int p = 1; p <= npulse; p++) begin
      @(negedge clk);
      inta_n = 1'b0;
      idle(6);
      if (p == 1) begin
        req_level = lv_late; req_valid = 1'b1;
        mode16 = ~m16;
      end
      e = exp_byte(m16, p, elv, base, vb, sp8);
      if (m16 && p == 1) chk("R4 silent first pulse", {23'd0, drive, data}, 32'(e));
      else if (!m16 && p == 1) chk("R2 call opcode", {23'd0, drive, data}, 32'(e));
      else if (m16) chk(vld ? "R6 pointer" : "R8 pointer lvl7", {23'd0, drive, data}, 32'(e));
      else chk(vld ? "R3 handler byte" : "R8 handler lvl7", {23'd0, drive, data}, 32'(e));
      inta_n = 1'b1;
      idle(6);
      chk("R9 released bus", {23'd0, drive, data}, 32'd0);
      if (p == 1) chk("R5 isr pulse after first", 32'(isr_cnt - isr0), 32'd1);
      if (p < npulse) chk("R7 no early clear", 32'(clr_cnt - clr0), 32'd0);
    end
    chk("R5 isr count", 32'(isr_cnt - isr0), 32'd1);
    chk(vld ? "R5 latched level" : "R8 level 7", 32'(isr_lvl), 32'(elv));
    chk("R5 level held", 32'(level), 32'(elv));
    chk("R7 auto clear", 32'(clr_cnt - clr0), ae ? 32'd1 : 32'd0);
  endtask

  initial begin
    idle(3);
    chk("R1 reset drive", 32'(drive), 32'd0);
    chk("R1 reset data", 32'(data), 32'd0);
    rst_n = 1'b1;
    idle(5);
    chk("R1 no isr pulse", 32'(isr_cnt), 32'd0);
    chk("R1 no clear pulse", 32'(clr_cnt), 32'd0);
    // directed corners
    run_seq(0, 1, 3'd5, 16'h1234, 5'h00, 0, 1, 3'd1);
    run_seq(0, 1, 3'd7, 16'hFFF0, 5'h00, 1, 0, 3'd0);   // R3 carry into high byte
    run_seq(0, 0, 3'd2, 16'h8000, 5'h00, 0, 1, 3'd4);   // R8
    run_seq(1, 1, 3'd3, 16'h0000, 5'h15, 0, 1, 3'd6);
    run_seq(1, 0, 3'd1, 16'h0000, 5'h0A, 1, 0, 3'd2);   // R8
    run_seq(1, 1, 3'd0, 16'h0000, 5'h1F, 0, 0, 3'd7);
    // R10 back-to-back mode switching
    run_seq(0, 1, 3'd6, 16'h00F8, 5'h03, 1, 1, 3'd0);
    run_seq(1, 1, 3'd4, 16'h00F8, 5'h03, 1, 1, 3'd0);
    void'($urandom(32'd4242));
    for (int i = 0; i < 150; i++) begin
      run_seq(1'($urandom), 1'($urandom_range(0, 3) != 0), 3'($urandom),
              16'($urandom), 5'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule